// File: doc/BRIEF.md
# Global Checkpoint Sequencer

This block runs a system-wide checkpoint across a set of save agents. The agents are cache or core state savers and memory log flushers. When a checkpoint starts, the sequencer raises one shared checkpoint level and asks the cores to pause. Each agent then saves or flushes in parallel and reports back on its own done line. Done reports are collected in a sticky mask, so the agents may finish in any order and in different cycles. Once every agent has reported, the sequencer drops the level. Every agent treats that falling edge as the moment to commit, either by flipping its bank or by marking its log boundary.

A checkpoint is started by an external trigger or by an internal interval timer that fires after a run of idle cycles. A trigger that arrives while a sequence is already running is dropped and is not queued. A watchdog counts cycles in the save phase and raises a sticky error flag if the agents take too long. On restart, a resume request puts the sequencer into a restore phase. During that phase a one-bit restoring indication is broadcast and the cores stay paused until every agent has reported.

Top module: `ckpt_sequencer`

## Requirements
- R1: During and right after reset, ckpt_o, pause_o, restoring_o and err_o are all 0.
- R2: With the sequencer idle and resume_i low, trig_i sampled high at a clock edge makes ckpt_o and pause_o high from that edge on. pause_o is high whenever ckpt_o is high.
- R3: ckpt_o stays high until every bit of done_i has been seen high at some edge since the checkpoint started. The bits may arrive in different cycles. ckpt_o falls at the edge where the last missing bit is seen.
- R4: done_i bits seen while idle, or at the edge that starts a checkpoint, do not count towards that checkpoint.
- R5: After ckpt_o falls there is exactly one commit cycle in which ckpt_o and pause_o are low and a trigger has no effect. The sequencer is then idle again, so a trigger held high starts a new checkpoint two cycles after the fall.
- R6: trig_i pulses during a checkpoint or a restore are ignored and are not remembered afterwards.
- R7: After PERIOD consecutive idle clock edges with no start, a checkpoint starts by itself (a PERIOD of 0 disables this).
- R8: If a checkpoint is still in its save phase after TIMEOUT edges, err_o goes high. err_o stays high through the commit and idle phases and returns to 0 at the edge that starts the next checkpoint.
- R9: resume_i sampled high while idle starts a restore: restoring_o and pause_o go high while ckpt_o stays low. resume_i has priority over trig_i at the same edge.
- R10: restoring_o stays high until every done_i bit has been seen since the restore started. It then falls and the sequencer is idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trig_i | input | 1 | Request to start a checkpoint |
| resume_i | input | 1 | Request to run a restore after restart |
| done_i | input | N_AGENTS | Per-agent save/flush/restore complete |
| ckpt_o | output | 1 | Shared checkpoint level; its falling edge commits |
| pause_o | output | 1 | Pause request to the cores |
| restoring_o | output | 1 | System is resuming from a checkpoint |
| err_o | output | 1 | Save phase exceeded the timeout |

## Verification
The bench builds the sequencer with four agents, a timeout of 12 cycles and an idle interval of 30 cycles. These small values bring the watchdog error and the self-started periodic checkpoint within a few dozen cycles of stimulus. With four agents there is room to deliver done bits one at a time, out of order, during idle and at the start edge. A reference model that tracks phase, mask, interval count and save count is compared against all four outputs on every clock.

// File: rtl/ckpt_pkg.sv
package ckpt_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_SAVE    = 2'd1,
        ST_COMMIT  = 2'd2,
        ST_RESTORE = 2'd3
    } seq_state_e;

    typedef struct packed {
        seq_state_e st;
        logic       err;
    } seq_regs_t;

endpackage

// File: rtl/ckpt_done_mask.sv
module ckpt_done_mask #(
    parameter int N_AGENTS = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clr,
    input  logic                acc,
    input  logic [N_AGENTS-1:0] done_i,
    output logic [N_AGENTS-1:0] mask_q,
    output logic                all_seen
);

    logic [N_AGENTS-1:0] mask_d;
    logic [N_AGENTS-1:0] seen;

    for (genvar g = 0; g < N_AGENTS; g++) begin : g_bit
        always_comb begin
            seen[g] = mask_q[g] | done_i[g];
            if (clr) begin
                mask_d[g] = 1'b0;
            end else if (acc) begin
                mask_d[g] = seen[g];
            end else begin
                mask_d[g] = mask_q[g];
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                mask_q[g] <= 1'b0;
            end else begin
                mask_q[g] <= mask_d[g];
            end
        end
    end

    assign all_seen = &seen;

endmodule

// File: rtl/ckpt_interval_timer.sv
module ckpt_interval_timer #(
    parameter int PERIOD = 200
) (
    input  logic clk,
    input  logic rst_n,
    input  logic idle,
    output logic hit
);

    if (PERIOD == 0) begin : g_off
        assign hit = 1'b0;
    end else begin : g_on
        localparam int CW = (PERIOD > 1) ? $clog2(PERIOD) : 1;
        logic [CW-1:0] cnt_d, cnt_q;

        always_comb begin
            hit = idle && (cnt_q == CW'(PERIOD - 1));
            if (!idle || hit) begin
                cnt_d = '0;
            end else begin
                cnt_d = cnt_q + 1'b1;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                cnt_q <= '0;
            end else begin
                cnt_q <= cnt_d;
            end
        end
    end

endmodule

// File: rtl/ckpt_save_watchdog.sv
module ckpt_save_watchdog #(
    parameter int TIMEOUT = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic run,
    output logic expired
);

    localparam int TW = $clog2(TIMEOUT + 1);

    logic [TW-1:0] cnt_d, cnt_q;

    always_comb begin
        expired = run && (cnt_q == TW'(TIMEOUT - 1));
        if (clr) begin
            cnt_d = '0;
        end else if (run && (cnt_q != TW'(TIMEOUT))) begin
            cnt_d = cnt_q + 1'b1;
        end else begin
            cnt_d = cnt_q;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

endmodule

// File: rtl/ckpt_sequencer.sv
module ckpt_sequencer
    import ckpt_pkg::*;
#(
    parameter int N_AGENTS = 4,
    parameter int TIMEOUT  = 64,
    parameter int PERIOD   = 200
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                trig_i,
    input  logic                resume_i,
    input  logic [N_AGENTS-1:0] done_i,
    output logic                ckpt_o,
    output logic                pause_o,
    output logic                restoring_o,
    output logic                err_o
);

    seq_regs_t           r_d, r_q;
    logic [N_AGENTS-1:0] mask_q;
    logic                all_seen;
    logic                period_hit;
    logic                expired;
    logic                start_ckpt;
    logic                start_rest;
    logic                in_idle, in_save, in_rest;

    always_comb begin
        in_idle    = (r_q.st == ST_IDLE);
        in_save    = (r_q.st == ST_SAVE);
        in_rest    = (r_q.st == ST_RESTORE);
        start_rest = in_idle && resume_i;
        start_ckpt = in_idle && !resume_i && (trig_i || period_hit);

        r_d = r_q;
        unique case (r_q.st)
            ST_IDLE: begin
                if (start_rest) begin
                    r_d.st = ST_RESTORE;
                end else if (start_ckpt) begin
                    r_d.st  = ST_SAVE;
                    r_d.err = 1'b0;
                end
            end
            ST_SAVE: begin
                if (all_seen) begin
                    r_d.st = ST_COMMIT;
                end else if (expired) begin
                    r_d.err = 1'b1;
                end
            end
            ST_COMMIT: begin
                r_d.st = ST_IDLE;
            end
            ST_RESTORE: begin
                if (all_seen) begin
                    r_d.st = ST_IDLE;
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: ST_IDLE, err: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    ckpt_done_mask #(.N_AGENTS(N_AGENTS)) u_mask (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (start_ckpt || start_rest),
        .acc     (in_save || in_rest),
        .done_i  (done_i),
        .mask_q  (mask_q),
        .all_seen(all_seen)
    );

    ckpt_interval_timer #(.PERIOD(PERIOD)) u_period (
        .clk  (clk),
        .rst_n(rst_n),
        .idle (in_idle),
        .hit  (period_hit)
    );

    ckpt_save_watchdog #(.TIMEOUT(TIMEOUT)) u_wdog (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (start_ckpt),
        .run    (in_save && !all_seen),
        .expired(expired)
    );

    assign ckpt_o      = in_save;
    assign pause_o     = in_save || in_rest;
    assign restoring_o = in_rest;
    assign err_o       = r_q.err;

endmodule

// File: rtl/ckpt_sequencer_chk.sv
module ckpt_sequencer_chk (
    input logic clk,
    input logic rst_n,
    input logic ckpt_o,
    input logic pause_o,
    input logic restoring_o,
    input logic err_o,
    input logic all_seen
);

    // R2
    pause_covers_ckpt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ckpt_o |-> pause_o);

    // R9
    phase_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(ckpt_o && restoring_o));

    // R9
    pause_covers_restore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        restoring_o |-> pause_o);

    // R3
    drop_after_all_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ckpt_o) |-> $past(all_seen));

    // R5
    commit_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ckpt_o) |=> !ckpt_o && !pause_o);

    // R8
    err_cleared_at_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ckpt_o) |-> !err_o);

    // R10
    restore_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(restoring_o) |-> $past(all_seen));

endmodule

bind ckpt_sequencer ckpt_sequencer_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ckpt_o     (ckpt_o),
    .pause_o    (pause_o),
    .restoring_o(restoring_o),
    .err_o      (err_o),
    .all_seen   (all_seen)
);

// File: tb/ckpt_sequencer_bench.sv
`timescale 1ns/1ps
module ckpt_sequencer_bench;

    localparam int N  = 4;
    localparam int TO = 12;
    localparam int PD = 30;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         trig_i = 1'b0;
    logic         resume_i = 1'b0;
    logic [N-1:0] done_i = '0;
    logic         ckpt_o, pause_o, restoring_o, err_o;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;

    always #2 clk = ~clk;

    ckpt_sequencer #(.N_AGENTS(N), .TIMEOUT(TO), .PERIOD(PD)) u_ckpt_sequencer (
        .clk(clk), .rst_n(rst_n), .trig_i(trig_i), .resume_i(resume_i),
        .done_i(done_i), .ckpt_o(ckpt_o), .pause_o(pause_o),
        .restoring_o(restoring_o), .err_o(err_o)
    );

    task automatic check(input string tag, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual=%b expected=%b at cycle %0d", tag, act, exp, cycles);
        end
    endtask

    // reference model: 0 idle, 1 save, 2 commit, 3 restore
    int           m_ph   = 0;
    logic [N-1:0] m_seen = '0;
    logic         m_err  = 1'b0;
    int           m_pcnt = 0;
    int           m_scnt = 0;

    always @(posedge clk) begin
        cycles++;
        if (!rst_n) begin
            m_ph = 0; m_seen = '0; m_err = 1'b0; m_pcnt = 0; m_scnt = 0;
        end else begin
            case (m_ph)
                0: begin
                    automatic bit hit = (m_pcnt == PD - 1);
                    m_pcnt = hit ? 0 : m_pcnt + 1;
                    if (resume_i) begin
                        m_ph = 3; m_seen = '0;
                    end else if (trig_i || hit) begin
                        m_ph = 1; m_seen = '0; m_err = 1'b0; m_scnt = 0;
                    end
                end
                1: begin
                    m_pcnt = 0;
                    if ((m_seen | done_i) == {N{1'b1}}) begin
                        m_ph = 2;
                    end else begin
                        m_seen = m_seen | done_i;
                        m_scnt++;
                        if (m_scnt == TO) m_err = 1'b1;
                    end
                end
                2: begin
                    m_pcnt = 0;
                    m_ph = 0;
                end
                default: begin
                    m_pcnt = 0;
                    if ((m_seen | done_i) == {N{1'b1}}) m_ph = 0;
                    else m_seen = m_seen | done_i;
                end
            endcase
        end
        #1;
        check("R3 ckpt_o vs model", ckpt_o, m_ph == 1);
        check("R2 pause_o vs model", pause_o, (m_ph == 1) || (m_ph == 3));
        check("R10 restoring_o vs model", restoring_o, m_ph == 3);
        check("R8 err_o vs model", err_o, m_err);
    end

    always @(posedge clk) begin
        if (cycles > 5000) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_all();
        done_i = '1; step(1); done_i = '0;
    endtask

    initial begin
        step(3);
        // R1
        check("R1 ckpt_o in reset", ckpt_o, 1'b0);
        check("R1 pause_o in reset", pause_o, 1'b0);
        check("R1 restoring_o in reset", restoring_o, 1'b0);
        check("R1 err_o in reset", err_o, 1'b0);
        rst_n = 1'b1;
        step(2);
        check("R1 ckpt_o after reset", ckpt_o, 1'b0);

        // R2 start on trigger
        trig_i = 1'b1; step(1); trig_i = 1'b0;
        check("R2 ckpt_o raised", ckpt_o, 1'b1);
        check("R2 pause_o raised", pause_o, 1'b1);
        // R3 staggered, out of order
        done_i = 4'b0100; step(1);
        done_i = 4'b0001; step(1);
        done_i = 4'b0000; step(1);
        done_i = 4'b1000; step(1);
        done_i = 4'b0000;
        check("R3 still waiting for bit1", ckpt_o, 1'b1);
        done_i = 4'b0010; step(1); done_i = '0;
        check("R3 fell after last bit", ckpt_o, 1'b0);
        // R5 commit cycle then idle
        step(1);
        check("R5 idle after commit", ckpt_o, 1'b0);

        // R4 done seen while idle and at start edge ignored
        done_i = '1; step(1);
        trig_i = 1'b1; step(1); trig_i = 1'b0; done_i = '0;
        check("R4 started", ckpt_o, 1'b1);
        step(2);
        check("R4 earlier done ignored", ckpt_o, 1'b1);
        // R6 triggers inside save ignored
        trig_i = 1'b1; step(2); trig_i = 1'b0;
        finish_all();
        check("R6 fell", ckpt_o, 1'b0);
        step(5);
        check("R6 no queued start", ckpt_o, 1'b0);

        // R5 trigger held across the fall
        trig_i = 1'b1; step(1);
        check("R5 start", ckpt_o, 1'b1);
        finish_all();
        check("R5 fall", ckpt_o, 1'b0);
        step(1);
        check("R5 commit ignores trigger", ckpt_o, 1'b0);
        step(1); trig_i = 1'b0;
        check("R5 restart after commit", ckpt_o, 1'b1);
        finish_all(); step(2);

        // R8 timeout
        trig_i = 1'b1; step(1); trig_i = 1'b0;
        done_i = 4'b0011; step(1); done_i = '0;
        step(TO - 3);
        check("R8 before timeout", err_o, 1'b0);
        step(3);
        check("R8 after timeout", err_o, 1'b1);
        finish_all(); step(3);
        check("R8 error kept when idle", err_o, 1'b1);
        trig_i = 1'b1; step(1); trig_i = 1'b0;
        check("R8 error cleared at start", err_o, 1'b0);
        finish_all(); step(2);

        // R7 periodic start
        begin
            automatic bit rose = 1'b0;
            for (int i = 0; i < PD + 4; i++) begin
                step(1);
                if (ckpt_o) rose = 1'b1;
            end
            check("R7 self-started", rose, 1'b1);
        end
        finish_all(); step(2);

        // R9 resume has priority over trigger
        resume_i = 1'b1; trig_i = 1'b1; step(1); resume_i = 1'b0; trig_i = 1'b0;
        check("R9 restoring_o", restoring_o, 1'b1);
        check("R9 ckpt_o low", ckpt_o, 1'b0);
        check("R9 pause_o", pause_o, 1'b1);
        trig_i = 1'b1; step(1); trig_i = 1'b0;
        // R10 staggered completion
        done_i = 4'b1010; step(1); done_i = '0; step(1);
        check("R10 waiting", restoring_o, 1'b1);
        done_i = 4'b0101; step(1); done_i = '0;
        check("R10 ended", restoring_o, 1'b0);
        check("R6 trigger in restore ignored", ckpt_o, 1'b0);
        step(3);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule